// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable single-port synchronous static RAM that can carry a transaction in every clock cycle, in any mix of reads and writes, with no idle cycle when the bus changes direction. The command, address and byte enables are captured on the rising clock edge. Read data then flows straight out of the array during the following cycle, with no output register. Write data trails its command by exactly one cycle and is committed on the next rising edge. Because a read and a write issued in consecutive cycles never need the data bus in the same cycle, the bus needs no turnaround gap.

A 2-bit burst counter sits under the low address bits. A registered advance input lets a read or write burst continue through up to four beats without a new address. The beat order is linear or interleaved, chosen by a static order pin that acts combinationally. The output enable also acts combinationally. The word is 18 bits wide and split into two 9-bit byte lanes, each with its own write enable. The depth is a parameter; the full part is 2^18 words, and the default is reduced so that the array fits on chip.

The control path is a three-state machine:
- `ST_DESEL`: no access.
- `ST_READ`: the registered beat is a read.
- `ST_WRITE`: the registered beat is a write.

Four transitions are taken at each edge:
- `T_DESEL`: select inactive and advance low, so the next state is `ST_DESEL`.
- `T_NEW_RD`: a new read is loaded, so the next state is `ST_READ`.
- `T_NEW_WR`: a new write is loaded, so the next state is `ST_WRITE`.
- `T_BURST`: advance is high, so the state holds (including `ST_DESEL`) and the counter steps.

Top module: `zbt_flow_sram`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) and after it is released, the block is deselected and `dout_drive` is 0 with `dout` equal to 0.
- R2: A read loaded at an edge (`adv`=0, `cs_n`=0, `we_n`=1) drives the addressed word on `dout` with `dout_drive`=1 during the very next cycle, provided `oe_n` is 0.
- R3: A write loaded at an edge (`adv`=0, `cs_n`=0, `we_n`=0) takes its data from `din` during the following cycle and commits it at the next edge. Only lanes whose `bw_n` bit was 0 with the command (or beat) are written: `bw_n[0]` covers bits 8:0 and `bw_n[1]` covers bits 17:9. The other lane keeps its old value.
- R4: Reads and writes may follow each other in consecutive cycles in any order. A read loaded right after a write to the same address returns the newly written data.
- R5: With `adv`=1 in an active state, the operation continues at the next beat. `cs_n`, `we_n` and `addr` are ignored, and the address bits above bit 1 are held. `bw_n` is sampled for each write beat.
- R6: With `lin_order`=1, beat k of a burst that starts at low offset s uses offset (s+k) mod 4.
- R7: With `lin_order`=0, beat k uses offset s XOR k. The pin acts combinationally on the current beat address.
- R8: `cs_n`=1 with `adv`=0 at an edge deselects the block, so `dout_drive` is 0 in the next cycle and nothing is written.
- R9: `adv`=1 while the block is deselected leaves it deselected.
- R10: `oe_n`=1 forces `dout_drive` to 0 and `dout` to 0 combinationally, and releasing it restores the read data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cs_n | input | 1 | Active-low select, sampled |
| adv | input | 1 | Burst advance, sampled; has priority over select |
| we_n | input | 1 | Active-low write command, sampled with a new address |
| bw_n | input | 2 | Active-low byte-lane write enables, sampled per beat |
| addr | input | ADDR_W | Word address, sampled on a load |
| din | input | 18 | Write data, presented the cycle after its command |
| oe_n | input | 1 | Active-low output enable, combinational |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved, combinational |
| dout | output | 18 | Flow-through read data, 0 when not driven |
| dout_drive | output | 1 | High when `dout` is actively driven (low models high impedance) |

## Verification
On every cycle, the assertions check the following:
- The load and advance rules of the burst counter, including that the high address bits are held during a burst.
- That a deselect or an advance while idle leaves the machine idle.
- That the output drive is dropped after a deselect.
- That each lane of a committed write either takes the new data or keeps its old value, as its enable dictates.

Only the bench scenarios can show the data-level results: the exact beat order in linear and interleaved mode, a same-address read returning freshly written data, combinational flipping of the order and output-enable pins, and a blocked write leaving the array untouched.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zbt_state_e;

    // Low two address bits of beat k of a burst starting at offset s
    function automatic logic [1:0] beat_offset(input logic [1:0] s,
                                               input logic [1:0] k,
                                               input logic       linear);
        return linear ? (s + k) : (s ^ k);
    endfunction

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output zbt_state_e        state,
    output logic [ADDR_W-1:0] base,
    output logic [1:0]        cnt,
    output logic [LANES-1:0]  lane_wr
);

    zbt_state_e nxt;
    logic       do_load;
    logic       do_step;

    // Next-state and action decode
    always_comb begin
        nxt     = state;
        do_load = 1'b0;
        do_step = 1'b0;
        unique case (state)
            ST_DESEL: begin
                if (adv) begin
                    nxt = ST_DESEL;                     // T_BURST from idle: hold
                end else if (cs_n) begin
                    nxt = ST_DESEL;                     // T_DESEL
                end else begin
                    do_load = 1'b1;
                    nxt     = we_n ? ST_READ : ST_WRITE; // T_NEW_RD / T_NEW_WR
                end
            end
            ST_READ, ST_WRITE: begin
                if (adv) begin
                    do_step = 1'b1;                     // T_BURST
                    nxt     = state;
                end else if (cs_n) begin
                    nxt = ST_DESEL;                     // T_DESEL
                end else begin
                    do_load = 1'b1;
                    nxt     = we_n ? ST_READ : ST_WRITE;
                end
            end
            default: nxt = ST_DESEL;
        endcase
    end

    // State and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_DESEL;
            base    <= '0;
            cnt     <= 2'd0;
            lane_wr <= '0;
        end else begin
            state <= nxt;
            if (do_load) begin
                base    <= addr;
                cnt     <= 2'd0;
                lane_wr <= ~bw_n;
            end else if (do_step) begin
                cnt     <= cnt + 2'd1;
                lane_wr <= ~bw_n;
            end else if (nxt == ST_DESEL) begin
                lane_wr <= '0;
            end
        end
    end

    // R5: a load captures the address and restarts the count
    p_load_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cs_n) |=> (cnt == 2'd0 && base == $past(addr)));

    // R5: an advance steps the count and holds the base and operation
    p_burst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state != ST_DESEL) |=>
            (cnt == $past(cnt) + 2'd1 && base == $past(base) && state == $past(state)));

    // R9: advance while idle stays idle
    p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state == ST_DESEL) |=> (state == ST_DESEL));

    // R8: a deselect is taken in one cycle
    p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && cs_n) |=> (state == ST_DESEL && lane_wr == '0));

endmodule

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        cnt,
    input  logic              linear,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - 2;

    logic [1:0] off;

    always_comb begin
        off      = beat_offset(base[1:0], cnt, linear);
        cur_addr = {base[ADDR_W-1:2], off};
    end

    initial begin
        assert (HI_W >= 1) else $error("address must be wider than the burst field");
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] wmask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wmask[l*LANE_W +: LANE_W] = {LANE_W{lane_en[l]}};

        // R3: an enabled lane takes the new data
        p_lane_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && lane_en[l]) |=>
                (mem[$past(addr)][l*LANE_W +: LANE_W] == $past(wdata[l*LANE_W +: LANE_W])));

        // R3: a masked lane keeps its old contents
        p_lane_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !lane_en[l]) |=>
                (mem[$past(addr)][l*LANE_W +: LANE_W] == $past(mem[addr][l*LANE_W +: LANE_W])));
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
        end
    end

    // Flow-through read port: no output register
    assign rdata = mem[addr];

    initial begin
        assert (LANES * LANE_W == DATA_W) else $error("data width must split evenly into lanes");
    end

endmodule

// File: rtl/zbt_flow_sram.sv
module zbt_flow_sram
    import zbt_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int LANES  = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    input  logic              lin_order,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);

    zbt_state_e        state;
    logic [ADDR_W-1:0] base;
    logic [1:0]        cnt;
    logic [LANES-1:0]  lane_wr;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rdata;
    logic              wr_en;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .adv     (adv),
        .we_n    (we_n),
        .bw_n    (bw_n),
        .addr    (addr),
        .state   (state),
        .base    (base),
        .cnt     (cnt),
        .lane_wr (lane_wr)
    );

    zbt_burst_addr #(.ADDR_W(ADDR_W)) u_baddr (
        .base     (base),
        .cnt      (cnt),
        .linear   (lin_order),
        .cur_addr (cur_addr)
    );

    assign wr_en = (state == ST_WRITE);

    zbt_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .lane_en (lane_wr),
        .addr    (cur_addr),
        .wdata   (din),
        .rdata   (rdata)
    );

    // Output process
    always_comb begin
        dout_drive = (state == ST_READ) && !oe_n;
        dout       = dout_drive ? rdata : '0;
    end

    // R8: outputs released the cycle after a deselect
    p_hiz_after_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && cs_n) |=> !dout_drive);

    // R2: a loaded read with output enabled drives in the next cycle
    p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cs_n && we_n) |=> (dout_drive == !oe_n));

endmodule

// File: tb/zbt_flow_sram_test.sv
module zbt_flow_sram_test;

    typedef struct packed {
        logic        cs_n;
        logic        adv;
        logic        we_n;
        logic [1:0]  bw_n;
        logic [7:0]  addr;
        logic [17:0] din;    // data for the previous cycle's write
        logic        drv;
        logic [17:0] dout;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,2'b00,8'h10,18'h00000,1'b0,18'h00000,8'd3}, // R3 write 0x10
        '{1'b0,1'b0,1'b0,2'b00,8'h11,18'h12345,1'b0,18'h00000,8'd3}, // R3 write 0x11
        '{1'b0,1'b0,1'b1,2'b00,8'h10,18'h0ABCD,1'b1,18'h12345,8'd2}, // R2 read after write
        '{1'b0,1'b0,1'b0,2'b10,8'h10,18'h00000,1'b0,18'h00000,8'd4}, // R4 lane0 only
        '{1'b0,1'b0,1'b1,2'b00,8'h10,18'h3FFFF,1'b1,18'h123FF,8'd4}, // R4 same-addr read
        '{1'b0,1'b0,1'b0,2'b01,8'h11,18'h00000,1'b0,18'h00000,8'd3}, // R3 lane1 only
        '{1'b0,1'b0,1'b1,2'b00,8'h11,18'h00000,1'b1,18'h001CD,8'd3}, // R3 lane kept
        '{1'b1,1'b0,1'b1,2'b11,8'h00,18'h00000,1'b0,18'h00000,8'd8}, // R8 deselect
        '{1'b1,1'b1,1'b1,2'b11,8'h00,18'h00000,1'b0,18'h00000,8'd9}, // R9 adv idle
        '{1'b0,1'b0,1'b0,2'b00,8'h20,18'h00000,1'b0,18'h00000,8'd5}, // R5 burst write
        '{1'b1,1'b1,1'b1,2'b00,8'h55,18'h00100,1'b0,18'h00000,8'd5}, // R5 adv
        '{1'b1,1'b1,1'b1,2'b00,8'h55,18'h00101,1'b0,18'h00000,8'd5}, // R5 adv
        '{1'b1,1'b1,1'b1,2'b00,8'h55,18'h00102,1'b0,18'h00000,8'd5}, // R5 adv
        '{1'b0,1'b0,1'b1,2'b00,8'h22,18'h00103,1'b1,18'h00102,8'd5}, // R5 read 0x22
        '{1'b0,1'b1,1'b0,2'b00,8'h55,18'h00000,1'b1,18'h00103,8'd6}, // R6 off 3
        '{1'b0,1'b1,1'b1,2'b00,8'h55,18'h00000,1'b1,18'h00100,8'd6}, // R6 wrap
        '{1'b0,1'b1,1'b1,2'b00,8'h55,18'h00000,1'b1,18'h00101,8'd6}, // R6 off 1
        '{1'b1,1'b0,1'b1,2'b11,8'h00,18'h00000,1'b0,18'h00000,8'd8}  // R8 release
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, adv, we_n, oe_n, lin_order;
    logic [1:0]  bw_n;
    logic [7:0]  addr;
    logic [17:0] din;
    logic [17:0] dout;
    logic        dout_drive;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    zbt_flow_sram uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n), .lin_order(lin_order),
        .dout(dout), .dout_drive(dout_drive)
    );

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic a, input logic w,
                        input logic [1:0] b, input logic [7:0] ad, input logic [17:0] d);
        @(negedge clk);
        cs_n = c; adv = a; we_n = w; bw_n = b; addr = ad; din = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; adv = 1'b0; we_n = 1'b1; bw_n = 2'b11;
        addr = '0; din = '0; oe_n = 1'b0; lin_order = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 drive in reset", {17'd0, dout_drive}, 18'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 2'b11, 8'h00, 18'h0);
        check("R1 drive after reset", {17'd0, dout_drive}, 18'd0);
        check("R1 dout after reset", dout, 18'd0);

        // Vector table walk (linear order, output enabled)
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].cs_n, TBL[i].adv, TBL[i].we_n, TBL[i].bw_n, TBL[i].addr, TBL[i].din);
            check($sformatf("R%0d row %0d drive", TBL[i].req, i), {17'd0, dout_drive}, {17'd0, TBL[i].drv});
            check($sformatf("R%0d row %0d data", TBL[i].req, i), dout, TBL[i].dout);
        end

        // R7: interleaved burst from offset 1: 1,0,3,2
        lin_order = 1'b0;
        step(1'b0, 1'b0, 1'b1, 2'b11, 8'h21, 18'h0);
        check("R7 beat0", dout, 18'h00101);
        step(1'b0, 1'b1, 1'b1, 2'b11, 8'h00, 18'h0);
        check("R7 beat1 interleaved", dout, 18'h00100);
        #1 lin_order = 1'b1;
        #1 check("R7 order pin combinational", dout, 18'h00102);
        lin_order = 1'b0;
        step(1'b0, 1'b1, 1'b1, 2'b11, 8'h00, 18'h0);
        check("R7 beat2 interleaved", dout, 18'h00103);
        step(1'b0, 1'b1, 1'b1, 2'b11, 8'h00, 18'h0);
        check("R7 beat3 interleaved", dout, 18'h00102);

        // R10: output enable acts combinationally
        #1 oe_n = 1'b1;
        #1 check("R10 oe_n high drive", {17'd0, dout_drive}, 18'd0);
        check("R10 oe_n high data", dout, 18'd0);
        oe_n = 1'b0;
        #1 check("R10 oe_n restored", dout, 18'h00102);

        // R8: a deselected write command changes nothing
        lin_order = 1'b1;
        step(1'b1, 1'b0, 1'b0, 2'b00, 8'h20, 18'h0);
        check("R8 deselect drive", {17'd0, dout_drive}, 18'd0);
        step(1'b1, 1'b0, 1'b1, 2'b11, 8'h00, 18'h3FFFF);
        step(1'b0, 1'b0, 1'b1, 2'b11, 8'h20, 18'h0);
        check("R8 no write when deselected", dout, 18'h00100);

        // R1: reset in the middle of a read
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 async reset drive", {17'd0, dout_drive}, 18'd0);
        cs_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 2'b11, 8'h00, 18'h0);
        check("R1 idle after reset", {17'd0, dout_drive}, 18'd0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule